// File: doc/BRIEF.md
# Interrupt source state controller

This block keeps the state of a fixed set of interrupt sources and turns their input events into offers for a single presentation unit. Each offer carries a source number, a priority and a target server. Every source holds three configured fields: a target server, a priority and a saved priority. Each source is also fixed by a parameter as either level-driven or message-driven, and keeps a few status flags. The flags a source uses depend on its kind. A level source tracks whether its line is asserted and whether its offer is outstanding. A message source tracks whether its last offer was rejected and whether it fired while masked. Priority 0xFF means masked.

The presentation unit talks back in three ways. It can reject a number, it can signal end of interrupt for a number, and it can ask for a resend. A resend walks every source, one per cycle, while `busy_o` is high.

A configuration port offers four operations: set entry, read entry, disable and enable. It answers one cycle later with a status code. Source numbers start at a base offset. Any number outside the table is refused.

Top module: `irq_source_ctrl`

## Requirements
- R1: A number is valid only in the range BASE to BASE+N_SRC-1. A config request on any other number answers code 0xFD (-3) and changes nothing. Reject and EOI requests on such a number are ignored.
- R2: A set-entry whose server is not below N_SRV answers 0xFD and leaves the entry unchanged.
- R3: A rising edge on the line of a message source with priority other than 0xFF queues an offer. The offer's number is BASE plus the source index, and it carries the entry's priority and server.
- R4: A message source that fires with priority 0xFF only records masked-pending. A later write of a priority other than 0xFF clears that flag and queues an offer.
- R5: On a level source, any change of its line sets or clears the asserted flag, and then a check runs. The check queues one offer and marks the source sent when three things hold: the priority is not 0xFF, the source is asserted, and it is not already sent. While sent, the source offers nothing more.
- R6: A reject marks the named source rejected and clears its sent flag.
- R7: An EOI clears the sent flag of a level source only. It makes no offer by itself.
- R8: resend_i starts a scan that visits one source per cycle, and busy_o stays high for exactly N_SRC cycles. A resend during a scan restarts it. On each visit, a level source runs the R5 check. A rejected message source clears its rejected flag and queues an offer if its priority is not 0xFF.
- R9: Disable writes priority 0xFF and keeps the old priority as the saved priority. Enable copies the saved priority into both fields. Both use the R4/R5 rules for their writes.
- R10: The response comes one cycle after the request. A success answers code 0x00. Read-entry returns the server and priority as they stood at the request.
- R11: Only one offer is shown at a time, and it is taken on offer_valid_o && offer_ready_i. Among the queued sources, the lowest index is shown first. An offer that has not been taken stays stable. A trigger that arrives in the cycle its own offer is taken queues a new offer.
- R12: After reset, every flag is clear, every server is 0, every priority and saved priority is 0xFF, and no offer, response or scan is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_line_i | input | N_SRC | Per-source event lines |
| cfg_valid_i | input | 1 | Config request strobe |
| cfg_op_i | input | 2 | 0 set, 1 read, 2 disable, 3 enable |
| cfg_num_i | input | NUM_W | Source number |
| cfg_srv_i | input | SRV_IN_W | Server for set |
| cfg_prio_i | input | 8 | Priority for set |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_code_o | output | 8 | 0x00 ok, 0xFD refused |
| rsp_srv_o | output | SRV_W | Entry server |
| rsp_prio_o | output | 8 | Entry priority |
| offer_valid_o | output | 1 | Offer shown |
| offer_ready_i | input | 1 | Presentation unit takes offer |
| offer_num_o | output | NUM_W | Offered source number |
| offer_srv_o | output | SRV_W | Offered target server |
| offer_prio_o | output | 8 | Offered priority |
| rej_valid_i | input | 1 | Reject strobe |
| rej_num_i | input | NUM_W | Rejected number |
| eoi_valid_i | input | 1 | EOI strobe |
| eoi_num_i | input | NUM_W | EOI number |
| resend_i | input | 1 | Start resend scan |
| busy_o | output | 1 | Scan in progress |

## Verification
The collision that matters is an offer being taken in the same cycle that its own source fires again. The queued flag must then end set, not cleared. The bench provokes this by holding offer_ready_i high while it raises the line of the message source whose offer is on display. It then requires the same number to be shown again on the next cycle, and to clear only after a second take. A second overlap covers two sources firing in one cycle: the lower index must be shown first and the other one right after it is taken.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;
  localparam logic [7:0] RSP_OK  = 8'h00;
  localparam logic [7:0] RSP_ERR = 8'hFD;  // -3
  typedef enum logic [1:0] {
    CFG_SET = 2'd0,
    CFG_GET = 2'd1,
    CFG_OFF = 2'd2,
    CFG_ON  = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/irq_src_entry.sv
module irq_src_entry
  import irq_src_pkg::*;
#(
  parameter bit IS_LVL = 1'b0,
  parameter int SRV_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              wr_i,
  input  logic [SRV_W-1:0]  wr_srv_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic [PRIO_W-1:0] wr_saved_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              scan_i,
  input  logic              take_i,
  output logic [SRV_W-1:0]  srv_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [PRIO_W-1:0] saved_o,
  output logic              want_o
);
  logic [SRV_W-1:0]  srv_q, srv_d;
  logic [PRIO_W-1:0] prio_q, prio_d, saved_q, saved_d;
  logic asrt_q, asrt_d, sent_q, sent_d, rej_q, rej_d, mp_q, mp_d;
  logic line_q, want_q, want_d;
  logic offer, lvl_chk;

  // Ordered steps within one cycle: reject, eoi, write, line, scan, level check.
  always_comb begin
    srv_d = srv_q; prio_d = prio_q; saved_d = saved_q;
    asrt_d = asrt_q; sent_d = sent_q; rej_d = rej_q; mp_d = mp_q;
    offer = 1'b0; lvl_chk = 1'b0;
    if (rej_i) begin
      rej_d = 1'b1;
      sent_d = 1'b0;
    end
    if (eoi_i && IS_LVL) sent_d = 1'b0;
    if (wr_i) begin
      srv_d = wr_srv_i; prio_d = wr_prio_i; saved_d = wr_saved_i;
      if (IS_LVL) lvl_chk = 1'b1;
      else if (mp_d && wr_prio_i != PRIO_MASKED) begin
        mp_d = 1'b0;
        offer = 1'b1;
      end
    end
    if (line_i != line_q) begin
      if (IS_LVL) begin
        asrt_d = line_i;
        lvl_chk = 1'b1;
      end else if (line_i) begin
        if (prio_d == PRIO_MASKED) mp_d = 1'b1;
        else offer = 1'b1;
      end
    end
    if (scan_i) begin
      if (IS_LVL) lvl_chk = 1'b1;
      else if (rej_d) begin
        rej_d = 1'b0;
        if (prio_d != PRIO_MASKED) offer = 1'b1;
      end
    end
    if (lvl_chk && prio_d != PRIO_MASKED && asrt_d && !sent_d) begin
      sent_d = 1'b1;
      offer = 1'b1;
    end
    want_d = (want_q & ~take_i) | offer;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srv_q <= '0; prio_q <= PRIO_MASKED; saved_q <= PRIO_MASKED;
      asrt_q <= 1'b0; sent_q <= 1'b0; rej_q <= 1'b0; mp_q <= 1'b0;
      line_q <= 1'b0; want_q <= 1'b0;
    end else begin
      srv_q <= srv_d; prio_q <= prio_d; saved_q <= saved_d;
      asrt_q <= asrt_d; sent_q <= sent_d; rej_q <= rej_d; mp_q <= mp_d;
      line_q <= line_i; want_q <= want_d;
    end
  end

  assign srv_o   = srv_q;
  assign prio_o  = prio_q;
  assign saved_o = saved_q;
  assign want_o  = want_q;
endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] want_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] take_o
);
  logic             hold_q, any;
  logic [IDX_W-1:0] hold_idx_q, pick;

  always_comb begin
    any = 1'b0;
    pick = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (want_i[i]) begin
        any = 1'b1;
        pick = IDX_W'(i);
      end
    end
  end

  // A shown but untaken offer is locked until taken.
  assign valid_o = hold_q | any;
  assign idx_o   = hold_q ? hold_idx_q : pick;

  always_comb begin
    take_o = '0;
    if (valid_o && ready_i) take_o[idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q <= valid_o && !ready_i;
      hold_idx_q <= idx_o;
    end
  end
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int N_SRV    = 4,
  parameter int BASE     = 16,
  parameter int NUM_W    = 12,
  parameter int SRV_IN_W = 8,
  parameter logic [N_SRC-1:0] LVL_MASK = 8'hF0,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int SRV_W = $clog2(N_SRV)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC-1:0]    src_line_i,
  input  logic                cfg_valid_i,
  input  logic [1:0]          cfg_op_i,
  input  logic [NUM_W-1:0]    cfg_num_i,
  input  logic [SRV_IN_W-1:0] cfg_srv_i,
  input  logic [PRIO_W-1:0]   cfg_prio_i,
  output logic                rsp_valid_o,
  output logic [7:0]          rsp_code_o,
  output logic [SRV_W-1:0]    rsp_srv_o,
  output logic [PRIO_W-1:0]   rsp_prio_o,
  output logic                offer_valid_o,
  input  logic                offer_ready_i,
  output logic [NUM_W-1:0]    offer_num_o,
  output logic [SRV_W-1:0]    offer_srv_o,
  output logic [PRIO_W-1:0]   offer_prio_o,
  input  logic                rej_valid_i,
  input  logic [NUM_W-1:0]    rej_num_i,
  input  logic                eoi_valid_i,
  input  logic [NUM_W-1:0]    eoi_num_i,
  input  logic                resend_i,
  output logic                busy_o
);
  function automatic logic in_rng(logic [NUM_W-1:0] n);
    return (32'(n) >= BASE) && (32'(n) < BASE + N_SRC);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(logic [NUM_W-1:0] n);
    return IDX_W'(32'(n) - BASE);
  endfunction

  logic [SRV_W-1:0]  srv_arr   [N_SRC];
  logic [PRIO_W-1:0] prio_arr  [N_SRC];
  logic [PRIO_W-1:0] saved_arr [N_SRC];
  logic [N_SRC-1:0]  want, take;

  cfg_op_e          op;
  logic             cfg_ok, cfg_wr;
  logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx, sel_idx;
  logic [SRV_W-1:0]  wr_srv;
  logic [PRIO_W-1:0] wr_prio, wr_saved;
  logic             rej_ok, eoi_ok;

  assign op      = cfg_op_e'(cfg_op_i);
  assign cfg_idx = to_idx(cfg_num_i);
  assign cfg_ok  = in_rng(cfg_num_i) &&
                   (op != CFG_SET || 32'(cfg_srv_i) < N_SRV);
  assign cfg_wr  = cfg_valid_i && cfg_ok && op != CFG_GET;
  assign rej_idx = to_idx(rej_num_i);
  assign eoi_idx = to_idx(eoi_num_i);
  assign rej_ok  = rej_valid_i && in_rng(rej_num_i);
  assign eoi_ok  = eoi_valid_i && in_rng(eoi_num_i);

  always_comb begin
    wr_srv = srv_arr[cfg_idx];
    wr_prio = saved_arr[cfg_idx];
    wr_saved = saved_arr[cfg_idx];
    unique case (op)
      CFG_SET: begin
        wr_srv = cfg_srv_i[SRV_W-1:0];
        wr_prio = cfg_prio_i;
        wr_saved = cfg_prio_i;
      end
      CFG_OFF: begin
        wr_prio = PRIO_MASKED;
        wr_saved = prio_arr[cfg_idx];
      end
      default: ;
    endcase
  end

  // Resend scan: one source per cycle.
  logic             busy_q;
  logic [IDX_W-1:0] scan_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      scan_q <= '0;
    end else if (resend_i) begin
      busy_q <= 1'b1;
      scan_q <= '0;
    end else if (busy_q) begin
      if (scan_q == IDX_W'(N_SRC - 1)) busy_q <= 1'b0;
      else scan_q <= scan_q + 1'b1;
    end
  end
  assign busy_o = busy_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_entry #(.IS_LVL(LVL_MASK[g]), .SRV_W(SRV_W)) i_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_i     (src_line_i[g]),
      .wr_i       (cfg_wr && cfg_idx == IDX_W'(g)),
      .wr_srv_i   (wr_srv),
      .wr_prio_i  (wr_prio),
      .wr_saved_i (wr_saved),
      .rej_i      (rej_ok && rej_idx == IDX_W'(g)),
      .eoi_i      (eoi_ok && eoi_idx == IDX_W'(g)),
      .scan_i     (busy_q && scan_q == IDX_W'(g)),
      .take_i     (take[g]),
      .srv_o      (srv_arr[g]),
      .prio_o     (prio_arr[g]),
      .saved_o    (saved_arr[g]),
      .want_o     (want[g])
    );
  end

  irq_src_arb #(.N_SRC(N_SRC)) i_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .want_i  (want),
    .ready_i (offer_ready_i),
    .valid_o (offer_valid_o),
    .idx_o   (sel_idx),
    .take_o  (take)
  );

  assign offer_num_o  = NUM_W'(BASE) + NUM_W'(sel_idx);
  assign offer_srv_o  = srv_arr[sel_idx];
  assign offer_prio_o = prio_arr[sel_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RSP_OK;
      rsp_srv_o   <= '0;
      rsp_prio_o  <= '0;
    end else begin
      rsp_valid_o <= cfg_valid_i;
      if (cfg_valid_i) begin
        rsp_code_o <= cfg_ok ? RSP_OK : RSP_ERR;
        rsp_srv_o  <= cfg_ok ? srv_arr[cfg_idx] : '0;
        rsp_prio_o <= cfg_ok ? prio_arr[cfg_idx] : '0;
      end
    end
  end
endmodule

// File: rtl/irq_src_chk.sv
module irq_src_chk #(
  parameter int NUM_W = 12,
  parameter int N_SRC = 8,
  parameter int BASE  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             offer_valid_o,
  input logic             offer_ready_i,
  input logic [NUM_W-1:0] offer_num_o,
  input logic             rsp_valid_o,
  input logic [7:0]       rsp_code_o,
  input logic             cfg_valid_i,
  input logic             busy_o,
  input logic             resend_i
);
  a_r11_offer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o && !offer_ready_i |=> offer_valid_o && $stable(offer_num_o));

  a_r1_offer_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o |-> (32'(offer_num_o) >= BASE) && (32'(offer_num_o) < BASE + N_SRC));

  a_r10_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_code_o == 8'h00) || (rsp_code_o == 8'hFD));

  a_r10_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(cfg_valid_i));

  a_r8_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(resend_i));
endmodule

bind irq_source_ctrl irq_src_chk #(.NUM_W(NUM_W), .N_SRC(N_SRC), .BASE(BASE)) i_irq_src_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .offer_valid_o (offer_valid_o),
  .offer_ready_i (offer_ready_i),
  .offer_num_o   (offer_num_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_code_o    (rsp_code_o),
  .cfg_valid_i   (cfg_valid_i),
  .busy_o        (busy_o),
  .resend_i      (resend_i)
);

// File: tb/test_irq_source_ctrl.sv
module test_irq_source_ctrl;
  import irq_src_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_SRC-1:0] line = '0;
  logic cfg_valid = 0; logic [1:0] cfg_op = 0; logic [11:0] cfg_num = 0;
  logic [7:0] cfg_srv = 0, cfg_prio = 0;
  logic rsp_valid; logic [7:0] rsp_code; logic [1:0] rsp_srv; logic [7:0] rsp_prio;
  logic offer_valid, offer_ready = 0; logic [11:0] offer_num;
  logic [1:0] offer_srv; logic [7:0] offer_prio;
  logic rej_valid = 0, eoi_valid = 0, resend = 0; logic [11:0] rej_num = 0, eoi_num = 0;
  logic busy;
  int total = 0, bad = 0;

  irq_source_ctrl i_irq_source_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_line_i(line),
    .cfg_valid_i(cfg_valid), .cfg_op_i(cfg_op), .cfg_num_i(cfg_num),
    .cfg_srv_i(cfg_srv), .cfg_prio_i(cfg_prio),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_srv_o(rsp_srv), .rsp_prio_o(rsp_prio),
    .offer_valid_o(offer_valid), .offer_ready_i(offer_ready), .offer_num_o(offer_num),
    .offer_srv_o(offer_srv), .offer_prio_o(offer_prio),
    .rej_valid_i(rej_valid), .rej_num_i(rej_num), .eoi_valid_i(eoi_valid), .eoi_num_i(eoi_num),
    .resend_i(resend), .busy_o(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0] op; logic [11:0] num; logic [7:0] srv; logic [7:0] prio;
    logic [7:0] code; logic chk; logic [1:0] esrv; logic [7:0] eprio;
  } vec_t;

  // R1 R2 R9 R10 R12 via config port
  localparam vec_t VECS [14] = '{
    '{CFG_GET, 12'd16, 8'd0, 8'd0,  8'h00, 1'b1, 2'd0, 8'hFF},
    '{CFG_GET, 12'd23, 8'd0, 8'd0,  8'h00, 1'b1, 2'd0, 8'hFF},
    '{CFG_GET, 12'd15, 8'd0, 8'd0,  8'hFD, 1'b0, 2'd0, 8'h00},
    '{CFG_GET, 12'd24, 8'd0, 8'd0,  8'hFD, 1'b0, 2'd0, 8'h00},
    '{CFG_SET, 12'd17, 8'd2, 8'd5,  8'h00, 1'b0, 2'd0, 8'h00},
    '{CFG_GET, 12'd17, 8'd0, 8'd0,  8'h00, 1'b1, 2'd2, 8'd5},
    '{CFG_SET, 12'd17, 8'd4, 8'd9,  8'hFD, 1'b0, 2'd0, 8'h00},
    '{CFG_GET, 12'd17, 8'd0, 8'd0,  8'h00, 1'b1, 2'd2, 8'd5},
    '{CFG_OFF, 12'd17, 8'd0, 8'd0,  8'h00, 1'b0, 2'd0, 8'h00},
    '{CFG_GET, 12'd17, 8'd0, 8'd0,  8'h00, 1'b1, 2'd2, 8'hFF},
    '{CFG_ON,  12'd17, 8'd0, 8'd0,  8'h00, 1'b0, 2'd0, 8'h00},
    '{CFG_GET, 12'd17, 8'd0, 8'd0,  8'h00, 1'b1, 2'd2, 8'd5},
    '{CFG_OFF, 12'd24, 8'd0, 8'd0,  8'hFD, 1'b0, 2'd0, 8'h00},
    '{CFG_ON,  12'd15, 8'd0, 8'd0,  8'hFD, 1'b0, 2'd0, 8'h00}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cfg(logic [1:0] op, int num, int srv, int prio);
    cfg_valid = 1; cfg_op = op; cfg_num = 12'(num); cfg_srv = 8'(srv); cfg_prio = 8'(prio);
    tick();
    cfg_valid = 0;
  endtask

  task automatic accept(); offer_ready = 1; tick(); offer_ready = 0; endtask
  task automatic pulse(int i); line[i] = 1; tick(); line[i] = 0; endtask
  task automatic reject(int n); rej_valid = 1; rej_num = 12'(n); tick(); rej_valid = 0; endtask
  task automatic eoi(int n); eoi_valid = 1; eoi_num = 12'(n); tick(); eoi_valid = 0; endtask

  task automatic do_resend(output int cnt);
    resend = 1; tick(); resend = 0;
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; tick(); end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R12 offer idle", offer_valid, 0);
    chk("R12 busy idle", busy, 0);
    chk("R12 rsp idle", rsp_valid, 0);

    foreach (VECS[k]) begin
      cfg(VECS[k].op, VECS[k].num, VECS[k].srv, VECS[k].prio);
      chk($sformatf("R10 rsp valid v%0d", k), rsp_valid, 1);
      chk($sformatf("R1 code v%0d", k), rsp_code, VECS[k].code);
      if (VECS[k].chk) begin
        chk($sformatf("R10 srv v%0d", k), rsp_srv, VECS[k].esrv);
        chk($sformatf("R10 prio v%0d", k), rsp_prio, VECS[k].eprio);
      end
      chk($sformatf("R2 no offer v%0d", k), offer_valid, 0);
    end

    // R3 message fire
    cfg(CFG_SET, 16, 1, 3);
    pulse(0);
    chk("R3 valid", offer_valid, 1);
    chk("R3 num", offer_num, 16);
    chk("R3 prio", offer_prio, 3);
    chk("R3 srv", offer_srv, 1);
    tick();
    chk("R11 held num", offer_num, 16);
    accept();
    chk("R11 taken", offer_valid, 0);

    // R8 rejected message re-offered by scan
    reject(16);
    chk("R6 no offer on reject", offer_valid, 0);
    do_resend(n);
    chk("R8 busy cycles", n, N_SRC);
    chk("R8 reoffer", offer_valid, 1);
    chk("R8 reoffer num", offer_num, 16);
    accept();
    do_resend(n);
    chk("R8 rejected cleared", offer_valid, 0);

    // R1 out-of-range reject ignored; R7 eoi on message source inert
    reject(24);
    eoi(16);
    do_resend(n);
    chk("R1 R7 ignored", offer_valid, 0);

    // R4 masked pending
    pulse(2);
    chk("R4 masked no offer", offer_valid, 0);
    cfg(CFG_SET, 18, 0, 7);
    chk("R4 offer on unmask", offer_valid, 1);
    chk("R4 num", offer_num, 18);
    chk("R4 prio", offer_prio, 7);
    accept();

    // R9 disable then enable
    cfg(CFG_OFF, 17, 0, 0);
    pulse(1);
    chk("R9 disabled no offer", offer_valid, 0);
    cfg(CFG_ON, 17, 0, 0);
    chk("R9 enable offers", offer_valid, 1);
    chk("R9 num", offer_num, 17);
    chk("R9 prio", offer_prio, 5);
    chk("R9 srv", offer_srv, 2);
    accept();

    // R5 level source
    cfg(CFG_SET, 20, 3, 2);
    chk("R5 unasserted no offer", offer_valid, 0);
    line[4] = 1; tick();
    chk("R5 offer", offer_valid, 1);
    chk("R5 num", offer_num, 20);
    chk("R5 srv", offer_srv, 3);
    accept(); tick();
    chk("R5 once while sent", offer_valid, 0);
    eoi(20);
    chk("R7 eoi no offer", offer_valid, 0);
    do_resend(n);
    chk("R7 reoffer after eoi", offer_valid, 1);
    chk("R7 num", offer_num, 20);
    accept();
    reject(20);
    do_resend(n);
    chk("R6 level reoffer", offer_valid, 1);
    accept();
    line[4] = 0; tick();
    reject(20);
    do_resend(n);
    chk("R5 deasserted no offer", offer_valid, 0);

    // R11 ordering and same-cycle take plus fire
    cfg(CFG_SET, 19, 0, 4);
    line[0] = 1; line[3] = 1; tick(); line[0] = 0; line[3] = 0;
    chk("R11 lowest first", offer_num, 16);
    accept();
    chk("R11 next", offer_num, 19);
    offer_ready = 1; line[3] = 1; tick(); offer_ready = 0; line[3] = 0;
    chk("R11 refire valid", offer_valid, 1);
    chk("R11 refire num", offer_num, 19);
    accept();
    chk("R11 drained", offer_valid, 0);

    // R8 restart during scan
    resend = 1; tick(); resend = 0;
    repeat (3) tick();
    do_resend(n);
    chk("R8 restart length", n, N_SRC);

    finish_up();
  end
endmodule